// File: doc/BRIEF.md
# Folded Symmetric 8-Tap FIR Datapath

This block is the arithmetic core of an eight-tap FIR filter for 10-bit samples. It uses the symmetry of the coefficients to need only four multipliers. Accepted samples enter a forward register chain that runs left to right. The tail of that chain feeds a reverse chain that runs right to left. Each of the four tap positions pairs one forward register with one reverse register, and those two samples always belong to mirror-image taps. A pre-adder adds or subtracts the pair, the result is multiplied by the shared coefficient, and the four products are summed into a full-precision accumulator. That sum can be rounded at a programmable binary weight.

The surrounding logic owns the coefficients and supplies them as four parallel words. It also sets the number formats, the add or subtract choice, the rounding controls and a decimation factor. A hold input freezes sample intake. A valid strobe marks the outputs that belong to the decimated stream.

Top module: `fir_fold8`

## Requirements
- R1: With `sub_i`=0 the output is y = Σ c_k·(x[n-k] + x[n-7+k]) for k = 0..3. Here x[n] is the newest accepted sample and c_k is `coef_i[10k+9:10k]`. Samples that were never accepted count as zero after reset.
- R2: With `sub_i`=1 each pair is differenced instead, giving y = Σ c_k·(x[n-k] − x[n-7+k]). This covers antisymmetric filters.
- R3: While `hold_i`=1 no sample is accepted. The chains keep their contents, `y_o` stays constant while the controls are constant, `vld_o` stays low, and the decimation count does not advance.
- R4: `dat_sgn_i`=0 reads samples as unsigned (0..1023). `dat_sgn_i`=1 reads them as two's complement (−512..511).
- R5: `cof_sgn_i`=0 reads coefficients as unsigned. `cof_sgn_i`=1 reads them as two's complement.
- R6: With `rnd_off_i`=0, a code p on `rnd_pos_i` rounds the sum half-up to a multiple of 2^p and leaves bits p-1..0 of `y_o` zero. The accumulator LSB carries weight 2^-10, so codes 0..11 select output weights 2^-10..2^1. Codes 12..15 behave as code 11.
- R7: With `rnd_off_i`=1 the exact sum appears on `y_o`, in 25-bit two's complement.
- R8: `vld_o` pulses for one cycle on every N-th accepted sample. N is `dec_i` limited to the range 2..16: values 0 and 1 act as 2, and values above 16 act as 16.
- R9: `y_o` and `vld_o` are registered. They reflect a sample accepted at clock edge E from edge E+1 onward, and `y_o` follows the chain state on every cycle.
- R10: While `rst` is high, `y_o` becomes 0, `vld_o` becomes 0, and the chains and the decimation count clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 10 | Sample input |
| hold_i | input | 1 | 1 = hold chains, 0 = accept sample and shift |
| dat_sgn_i | input | 1 | Sample format: 0 unsigned, 1 two's complement |
| cof_sgn_i | input | 1 | Coefficient format: 0 unsigned, 1 two's complement |
| sub_i | input | 1 | Pre-adder mode: 0 add, 1 subtract |
| rnd_off_i | input | 1 | 0 = rounding active, 1 = bypass |
| rnd_pos_i | input | 4 | Rounding weight code |
| dec_i | input | 5 | Decimation factor |
| coef_i | input | 40 | Four pair coefficients, pair k in bits 10k+9..10k |
| y_o | output | 25 | Filtered sum |
| vld_o | output | 1 | Decimated output strobe |

## Verification
The bench builds the block with its default sizes: 10-bit samples and coefficients and four folded pairs. At that size the bench can sweep every combination of sample format, coefficient format, pre-adder mode, rounding bypass and all sixteen rounding codes, including the four out-of-range codes. Sample and coefficient values are taken from the extremes of both formats (0, 0x1FF, 0x200, 0x3FF) mixed with random values, so the worst-case signs and magnitudes reach the accumulator. The five-bit decimation input is small enough to cover the clamped values 0, 1, 17 and 31 next to legal factors, both with back-to-back samples and with held gaps.

// File: rtl/fir_fold8.sv
module fir_fold8 #(
  parameter int DW      = 10,
  parameter int CW      = 10,
  parameter int HALF    = 4,
  parameter int RPW     = 4,
  parameter int RND_MAX = 11,
  parameter int DECW    = 5,
  parameter int DMIN    = 2,
  parameter int DMAX    = 16,
  localparam int PW     = DW + 2,
  localparam int MW     = PW + CW + 1,
  localparam int AW     = MW + $clog2(HALF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      x_i,
  input  logic               hold_i,
  input  logic               dat_sgn_i,
  input  logic               cof_sgn_i,
  input  logic               sub_i,
  input  logic               rnd_off_i,
  input  logic [RPW-1:0]     rnd_pos_i,
  input  logic [DECW-1:0]    dec_i,
  input  logic [HALF*CW-1:0] coef_i,
  output logic [AW-1:0]      y_o,
  output logic               vld_o
);

  logic [DW-1:0] fwd [HALF];
  logic [DW-1:0] rev [HALF];
  logic signed [MW-1:0] prod [HALF];
  logic signed [AW-1:0] acc;
  logic [AW-1:0] half_lsb, keep, rnd;
  logic [RPW-1:0] rp;
  logic [DECW-1:0] dec_eff, cnt;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HALF; k++) begin
        fwd[k] <= '0;
        rev[k] <= '0;
      end
    end else if (!hold_i) begin
      fwd[0]      <= x_i;
      rev[HALF-1] <= fwd[HALF-1];
      for (int k = 1; k < HALF; k++) fwd[k] <= fwd[k-1];
      for (int k = 0; k < HALF-1; k++) rev[k] <= rev[k+1];
    end
  end

  for (genvar g = 0; g < HALF; g++) begin : g_pair
    logic signed [DW:0]   fa, rb;
    logic signed [PW-1:0] pre;
    logic signed [CW:0]   cf;
    assign fa  = {dat_sgn_i & fwd[g][DW-1], fwd[g]};
    assign rb  = {dat_sgn_i & rev[g][DW-1], rev[g]};
    assign pre = sub_i ? PW'(fa) - PW'(rb) : PW'(fa) + PW'(rb);
    assign cf  = {cof_sgn_i & coef_i[g*CW+CW-1], coef_i[g*CW +: CW]};
    assign prod[g] = MW'(pre) * MW'(cf);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < HALF; k++) acc = acc + AW'(prod[k]);
  end

  assign rp       = (rnd_pos_i > RPW'(RND_MAX)) ? RPW'(RND_MAX) : rnd_pos_i;
  assign half_lsb = (rp == '0) ? '0 : (AW'(1) << (rp - 1'b1));
  assign keep     = ~((AW'(1) << rp) - AW'(1));
  assign rnd      = (AW'(acc) + half_lsb) & keep;

  assign dec_eff = (dec_i < DECW'(DMIN)) ? DECW'(DMIN) :
                   (dec_i > DECW'(DMAX)) ? DECW'(DMAX) : dec_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= 1'b0;
      vld_o <= 1'b0;
      y_o   <= '0;
    end else begin
      vld_o <= pend;
      y_o   <= rnd_off_i ? AW'(acc) : rnd;
      if (hold_i) begin
        pend <= 1'b0;
      end else if (cnt >= dec_eff - 1'b1) begin
        cnt  <= '0;
        pend <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fir_fold8_chk.sv
module fir_fold8_chk #(
  parameter int CW   = 10,
  parameter int HALF = 4,
  parameter int RPW  = 4,
  parameter int AW   = 25
) (
  input logic               clk,
  input logic               rst,
  input logic               hold_i,
  input logic               dat_sgn_i,
  input logic               cof_sgn_i,
  input logic               sub_i,
  input logic               rnd_off_i,
  input logic [RPW-1:0]     rnd_pos_i,
  input logic [HALF*CW-1:0] coef_i,
  input logic [AW-1:0]      y_o,
  input logic               vld_o
);

  logic [RPW-1:0] rpc;
  logic [AW-1:0]  lowm;
  assign rpc  = (rnd_pos_i > RPW'(11)) ? RPW'(11) : rnd_pos_i;
  assign lowm = (AW'(1) << rpc) - AW'(1);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (y_o == '0 && !vld_o));

  assert_hold_freezes_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_i) && !$past(rst) && $stable(coef_i) &&
     $stable({dat_sgn_i, cof_sgn_i, sub_i, rnd_off_i, rnd_pos_i}))
    |=> $stable(y_o));

  assert_round_low_bits_R6: assert property (@(posedge clk) disable iff (rst)
    !rnd_off_i |=> ((y_o & $past(lowm)) == '0));

  assert_vld_single_R8: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);

  assert_vld_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !$past(rst) && !$past(rst, 2)) |-> !$past(hold_i, 2));

endmodule

bind fir_fold8 fir_fold8_chk #(.CW(CW), .HALF(HALF), .RPW(RPW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .hold_i(hold_i), .dat_sgn_i(dat_sgn_i),
  .cof_sgn_i(cof_sgn_i), .sub_i(sub_i), .rnd_off_i(rnd_off_i),
  .rnd_pos_i(rnd_pos_i), .coef_i(coef_i), .y_o(y_o), .vld_o(vld_o)
);

// File: tb/tb_fir_fold8.sv
module tb_fir_fold8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] x_i = '0;
  logic hold_i = 1'b1;
  logic ds = 0, cs = 0, sb = 0, ro = 1;
  logic [3:0] rp = '0;
  logic [4:0] dec = 5'd16;
  logic [9:0] cf [4] = '{default: '0};
  logic [24:0] y_o;
  logic vld_o;

  int total = 0, fails = 0;
  logic [9:0] hist [8];
  int mcnt = 0, nd = 16;

  always #10 clk = ~clk;

  fir_fold8 dut (
    .clk(clk), .rst(rst), .x_i(x_i), .hold_i(hold_i), .dat_sgn_i(ds),
    .cof_sgn_i(cs), .sub_i(sb), .rnd_off_i(ro), .rnd_pos_i(rp), .dec_i(dec),
    .coef_i({cf[3], cf[2], cf[1], cf[0]}), .y_o(y_o), .vld_o(vld_o)
  );

  task automatic chk(string req, logic [24:0] act, logic [24:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sv(logic [9:0] v, logic s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [24:0] expv();
    longint acc = 0;
    int p;
    for (int k = 0; k < 4; k++) begin
      longint d = sb ? sv(hist[k], ds) - sv(hist[7-k], ds)
                     : sv(hist[k], ds) + sv(hist[7-k], ds);
      acc += sv(cf[k], cs) * d;
    end
    p = (rp > 11) ? 11 : int'(rp);
    if (!ro && p > 0) acc = ((acc + (64'sd1 <<< (p - 1))) >>> p) <<< p;
    return acc[24:0];
  endfunction

  function automatic logic [9:0] pick();
    case ($urandom_range(0, 5))
      0: return 10'h000;
      1: return 10'h3FF;
      2: return 10'h200;
      3: return 10'h1FF;
      default: return 10'($urandom);
    endcase
  endfunction

  function automatic bit push(logic [9:0] v);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    mcnt++;
    if (mcnt == nd) begin
      mcnt = 0;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic do_reset(logic [4:0] d);
    rst = 1'b1; hold_i = 1'b1; dec = d;
    nd = (d < 2) ? 2 : (d > 16) ? 16 : int'(d);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) hist[i] = '0;
    mcnt = 0;
    chk("R10 y after reset", y_o, '0);
    chk("R10 vld after reset", {24'd0, vld_o}, '0);
  endtask

  task automatic cap(string tag, logic [9:0] v);
    bit hit;
    @(negedge clk) x_i = v; hold_i = 1'b0;
    @(negedge clk) hold_i = 1'b1;
    hit = push(v);
    @(negedge clk);
    chk(tag, y_o, expv());
    chk("R8 vld on N-th sample", {24'd0, vld_o}, {24'd0, hit});
  endtask

  task automatic stream(int n);
    logic [24:0] prev_y;
    bit prev_v, hit;
    logic [9:0] v;
    prev_y = expv(); prev_v = 1'b0;
    v = pick();
    @(negedge clk) x_i = v; hold_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit = push(v);
      chk("R9 back-to-back y lags one edge", y_o, prev_y);
      chk("R8 vld streaming", {24'd0, vld_o}, {24'd0, prev_v});
      prev_y = expv(); prev_v = hit;
      v = pick(); x_i = v;
    end
    hold_i = 1'b1;
    @(negedge clk);
    chk("R9 last streamed y", y_o, prev_y);
    chk("R8 last streamed vld", {24'd0, vld_o}, {24'd0, prev_v});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [24:0] held;
    do_reset(5'd16);

    // R1 impulse through the fold: each pair coefficient appears twice
    ds = 0; cs = 0; sb = 0; ro = 1;
    cf[0] = 10'd1; cf[1] = 10'd2; cf[2] = 10'd4; cf[3] = 10'd8;
    cap("R1 impulse", 10'd1);
    for (int i = 0; i < 8; i++) cap("R1 impulse tail", 10'd0);
    sb = 1;
    cap("R2 impulse", 10'd1);
    for (int i = 0; i < 8; i++) cap("R2 antisymmetric tail", 10'd0);

    // R1 R2 R4 R5 R6 R7 sweep over every control combination
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 32; r++) begin
        ds = c[0]; cs = c[1]; sb = c[2]; ro = r[4]; rp = 4'(r);
        for (int k = 0; k < 4; k++) cf[k] = pick();
        for (int s = 0; s < 3; s++)
          cap(sb ? "R2 R4 R5 R6 R7 sweep" : "R1 R4 R5 R6 R7 sweep", pick());
      end
    end

    // R3 hold: inputs wiggle, nothing moves
    ds = 1; cs = 1; sb = 0; ro = 0; rp = 4'd3;
    for (int k = 0; k < 4; k++) cf[k] = pick();
    for (int i = 0; i < 8; i++) cap("R4 R5 R6 fill", pick());
    held = y_o;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) x_i = 10'($urandom);
      chk("R3 y frozen while held", y_o, held);
      chk("R3 vld low while held", {24'd0, vld_o}, '0);
    end
    cap("R3 chain intact after hold", pick());

    // R8 R9 decimation, including clamped factors
    begin
      logic [4:0] dl [8] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd7, 5'd16, 5'd17, 5'd31};
      for (int j = 0; j < 8; j++) begin
        do_reset(dl[j]);
        ro = j[0]; rp = 4'(j + 5);
        stream(40);
        for (int i = 0; i < 5; i++) cap("R3 R8 count across gaps", pick());
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule